// File: doc/BRIEF.md
# Memory-Mapped Keyboard Input Port

This block connects a character-producing keyboard front end to a 16-bit memory-mapped processor bus. The device side offers an 8-bit character together with a single-cycle strobe. The port latches that character, raises a ready flag, and can request an interrupt. The processor polls a status word or takes the interrupt, then fetches the character by reading a data word. That read hands the buffer back to the keyboard.

Only one character is held at a time. While a character waits unread, the keyboard is locked out and any further strobes are discarded. The one exception is a strobe that arrives in the same cycle as the data-word read: the read consumes the old character and the new one is accepted at once. On every read that hits one of its two words, the port asserts a load-path select, so the processor takes device data instead of main-memory data.

Top module: `kbd_mmio_port`

## Requirements
- R1: The status word responds only at bus address 0xFE00 and the data word only at 0xFE02, both compared on all 16 bits. `dev_sel` is 1 exactly when `bus_rd` is 1 and the address is one of those two. `bus_rdata` is zero whenever `dev_sel` is 0.
- R2: After a synchronous reset, the ready bit, the interrupt-enable bit and the held character are all 0. Both words then read as 0x0000.
- R3: A `key_strobe` seen while ready is 0 stores `key_char`, and ready reads as 1 from the next cycle.
- R4: While ready is 1, a strobe in a cycle that does not read the data word is dropped, and the held character stays unchanged.
- R5: A data-word read returns the held character in bits 7:0 with bits 15:8 zero, and ready is 0 from the next cycle unless R9 applies.
- R6: A status read returns ready in bit 15 and interrupt-enable in bit 14, with bits 13:0 zero.
- R7: A bus write to 0xFE00 loads interrupt-enable from write-data bit 14. Bit 15 of that write is ignored, and writes to 0xFE02 change nothing.
- R8: `irq` is 1 exactly when ready and interrupt-enable are both 1.
- R9: When a strobe and a data-word read occur in the same cycle, the read returns the old character, the new character is stored, and ready stays 1.
- R10: `kbd_enabled` is 1 exactly when ready is 0, meaning the keyboard may deliver a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Read request this cycle |
| bus_wr | input | 1 | Write request this cycle |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Device read data, zero when not selected |
| dev_sel | output | 1 | Load path takes device data instead of memory |
| key_strobe | input | 1 | Device-side character valid pulse |
| key_char | input | 8 | Device-side character code |
| kbd_enabled | output | 1 | Keyboard may deliver a character |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never both 1 in the same cycle. They also assume that `key_char` is meaningful only while `key_strobe` is 1, and that each strobe is a separate event sampled at one edge. The bench keeps within this: every bus access is a single-cycle task that raises exactly one of the two request lines, and each strobe lasts one cycle with the character driven alongside it. The character sweep covers all 256 codes under both interrupt-enable settings. The address sweep covers the whole reserved 0xFE00 to 0xFFFF window plus a few ordinary memory addresses.

// File: rtl/kbd_mmio_pkg.sv
package kbd_mmio_pkg;

    localparam int BUS_W    = 16;
    localparam int CHAR_W   = 8;
    localparam int RDY_BIT  = 15;
    localparam int IEN_BIT  = 14;

    localparam logic [BUS_W-1:0] STAT_ADDR = 16'hFE00;
    localparam logic [BUS_W-1:0] DATA_ADDR = 16'hFE02;

    typedef enum logic [1:0] {
        HIT_NONE   = 2'd0,
        HIT_STATUS = 2'd1,
        HIT_DATA   = 2'd2
    } reg_hit_e;

    typedef struct packed {
        logic             ready;
        logic             ien;
        logic [CHAR_W-1:0] chr;
    } port_state_t;

    function automatic reg_hit_e decode_addr(input logic [BUS_W-1:0] a,
                                             input logic [BUS_W-1:0] sa,
                                             input logic [BUS_W-1:0] da);
        if (a == sa)      return HIT_STATUS;
        else if (a == da) return HIT_DATA;
        else              return HIT_NONE;
    endfunction

    function automatic logic [BUS_W-1:0] pack_status(input port_state_t s);
        logic [BUS_W-1:0] w;
        w = '0;
        w[RDY_BIT] = s.ready;
        w[IEN_BIT] = s.ien;
        return w;
    endfunction

    function automatic logic [BUS_W-1:0] pack_data(input port_state_t s);
        return {{(BUS_W-CHAR_W){1'b0}}, s.chr};
    endfunction

endpackage

// File: rtl/kbd_addr_decode.sv
module kbd_addr_decode
    import kbd_mmio_pkg::*;
#(
    parameter int               ADDR_W = BUS_W,
    parameter logic [ADDR_W-1:0] S_ADDR = STAT_ADDR,
    parameter logic [ADDR_W-1:0] D_ADDR = DATA_ADDR
)(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output reg_hit_e          hit,
    output logic              rd_data,
    output logic              wr_status
);
    always_comb begin
        hit       = decode_addr(addr, S_ADDR, D_ADDR);
        rd_data   = rd && (hit == HIT_DATA);
        wr_status = wr && (hit == HIT_STATUS);
    end
endmodule

// File: rtl/kbd_char_buffer.sv
module kbd_char_buffer
    import kbd_mmio_pkg::*;
#(
    parameter int CW = CHAR_W
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic [CW-1:0] chr_in,
    input  logic          consume,
    output logic          ready,
    output logic [CW-1:0] chr_q
);
    logic accept;

    // A consuming read frees the slot in the same cycle a strobe may refill it.
    always_comb accept = strobe && (!ready || consume);

    always_ff @(posedge clk) begin
        if (rst) begin
            ready <= 1'b0;
            chr_q <= '0;
        end else begin
            if (accept) begin
                chr_q <= chr_in;
                ready <= 1'b1;
            end else if (consume) begin
                ready <= 1'b0;
            end
        end
    end

    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (strobe && !ready) |=> (ready && chr_q == $past(chr_in)));

    p_lockout_r4: assert property (@(posedge clk) disable iff (rst)
        (ready && !consume) |=> (ready && $stable(chr_q)));

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (ready && consume && !strobe) |=> !ready);

    p_collide_r9: assert property (@(posedge clk) disable iff (rst)
        (ready && consume && strobe) |=> (ready && chr_q == $past(chr_in)));

    p_ready_src_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(strobe));
endmodule

// File: rtl/kbd_ctrl_reg.sv
module kbd_ctrl_reg
    import kbd_mmio_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic ien_in,
    output logic ien
);
    always_ff @(posedge clk) begin
        if (rst)        ien <= 1'b0;
        else if (wr_en) ien <= ien_in;
    end

    p_ien_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ien));

    p_ien_load_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ien == $past(ien_in)));
endmodule

// File: rtl/kbd_read_mux.sv
module kbd_read_mux
    import kbd_mmio_pkg::*;
(
    input  logic              rd,
    input  reg_hit_e          hit,
    input  port_state_t       st,
    output logic [BUS_W-1:0]  rdata,
    output logic              sel
);
    always_comb begin
        sel   = 1'b0;
        rdata = '0;
        if (rd) begin
            unique case (hit)
                HIT_STATUS: begin sel = 1'b1; rdata = pack_status(st); end
                HIT_DATA:   begin sel = 1'b1; rdata = pack_data(st);   end
                default:    begin sel = 1'b0; rdata = '0;              end
            endcase
        end
    end

    always_comb begin
        if (!sel) a_quiet_r1: assert (rdata == '0);
        if (sel)  a_sel_rd_r1: assert (rd);
    end
endmodule

// File: rtl/kbd_mmio_port.sv
module kbd_mmio_port
    import kbd_mmio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_W-1:0]  bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              dev_sel,
    input  logic              key_strobe,
    input  logic [CHAR_W-1:0] key_char,
    output logic              kbd_enabled,
    output logic              irq
);
    reg_hit_e          hit;
    logic              rd_data;
    logic              wr_status;
    logic              ready;
    logic              ien;
    logic [CHAR_W-1:0] chr_q;
    port_state_t       st;
    logic              unused_wdata;

    assign unused_wdata = ^{bus_wdata[BUS_W-1:IEN_BIT+1], bus_wdata[IEN_BIT-1:0]};

    kbd_addr_decode u_dec (
        .addr      (bus_addr),
        .rd        (bus_rd),
        .wr        (bus_wr),
        .hit       (hit),
        .rd_data   (rd_data),
        .wr_status (wr_status)
    );

    kbd_char_buffer u_buf (
        .clk     (clk),
        .rst     (rst),
        .strobe  (key_strobe),
        .chr_in  (key_char),
        .consume (rd_data),
        .ready   (ready),
        .chr_q   (chr_q)
    );

    kbd_ctrl_reg u_ctl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_status),
        .ien_in (bus_wdata[IEN_BIT]),
        .ien    (ien)
    );

    always_comb begin
        st.ready = ready;
        st.ien   = ien;
        st.chr   = chr_q;
    end

    kbd_read_mux u_mux (
        .rd    (bus_rd),
        .hit   (hit),
        .st    (st),
        .rdata (bus_rdata),
        .sel   (dev_sel)
    );

    always_comb begin
        irq         = ready && ien;
        kbd_enabled = !ready;
    end

    p_irq_status_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == STAT_ADDR) |-> (irq == (bus_rdata[RDY_BIT] && bus_rdata[IEN_BIT])));

    p_enable_status_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == STAT_ADDR) |-> (kbd_enabled == !bus_rdata[RDY_BIT]));

    p_status_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == STAT_ADDR) |-> (bus_rdata[IEN_BIT-1:0] == '0));

    p_data_high_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == DATA_ADDR) |-> (bus_rdata[BUS_W-1:CHAR_W] == '0));

    p_sel_addr_r1: assert property (@(posedge clk) disable iff (rst)
        dev_sel |-> (bus_addr == STAT_ADDR || bus_addr == DATA_ADDR));

    p_ready_after_reset_r2: assert property (@(posedge clk)
        $past(rst) |-> (kbd_enabled && !irq));
endmodule

// File: tb/kbd_mmio_port_tb_top.sv
module kbd_mmio_port_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        dev_sel;
    logic        key_strobe = 1'b0;
    logic [7:0]  key_char = '0;
    logic        kbd_enabled;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    kbd_mmio_port dut_i (.*);

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus/device cycle: drive at negedge, sample combinational outputs, pass the edge.
    task automatic cycle(input logic rd, input logic wr, input logic [15:0] a, input logic [15:0] wd,
                         input logic stb, input logic [7:0] ch,
                         output logic [15:0] rdat, output logic sel);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        key_strobe = stb; key_char = ch;
        #1;
        rdat = bus_rdata; sel = dev_sel;
        @(posedge clk);
        #1;
        bus_rd = 0; bus_wr = 0; key_strobe = 0;
    endtask

    task automatic rd_word(input logic [15:0] a, output logic [15:0] d, output logic s);
        cycle(1'b1, 1'b0, a, 16'h0, 1'b0, 8'h0, d, s);
    endtask

    task automatic wr_word(input logic [15:0] a, input logic [15:0] w);
        logic [15:0] d; logic s;
        cycle(1'b0, 1'b1, a, w, 1'b0, 8'h0, d, s);
    endtask

    task automatic strobe(input logic [7:0] c);
        logic [15:0] d; logic s;
        cycle(1'b0, 1'b0, 16'h0, 16'h0, 1'b1, c, d, s);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic s;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R2 reset state
        rd_word(16'hFE00, d, s);
        chk(d == 16'h0000 && s, "R2 status after reset", d, 16'h0000);
        rd_word(16'hFE02, d, s);
        chk(d == 16'h0000, "R2 data after reset", d, 16'h0000);
        chk(kbd_enabled == 1'b1, "R10 enabled after reset", {15'h0, kbd_enabled}, 16'h1);
        chk(irq == 1'b0, "R8 irq after reset", {15'h0, irq}, 16'h0);

        // R7 ready bit not writable; ie bit writable
        wr_word(16'hFE00, 16'h8000);
        rd_word(16'hFE00, d, s);
        chk(d == 16'h0000, "R7 write to ready ignored", d, 16'h0000);
        wr_word(16'hFE00, 16'hFFFF);
        rd_word(16'hFE00, d, s);
        chk(d == 16'h4000, "R7 ie set, ready untouched, R6 low bits zero", d, 16'h4000);
        chk(irq == 1'b0, "R8 no irq without ready", {15'h0, irq}, 16'h0);
        wr_word(16'hFE00, 16'h0000);

        // Sweep all characters under both ie settings
        for (int ie = 0; ie < 2; ie++) begin
            wr_word(16'hFE00, ie[0] ? 16'h4000 : 16'h0000);
            for (int c = 0; c < 256; c++) begin
                logic [7:0] ch;
                ch = c[7:0];
                strobe(ch);
                chk(kbd_enabled == 1'b0, "R10 locked after capture", {15'h0, kbd_enabled}, 16'h0);
                chk(irq == ie[0], "R8 irq follows ready and ie", {15'h0, irq}, {15'h0, ie[0]});
                rd_word(16'hFE00, d, s);
                chk(d == {1'b1, ie[0], 14'h0}, "R3 R6 status after capture", d, {1'b1, ie[0], 14'h0});
                strobe(~ch);
                rd_word(16'hFE02, d, s);
                chk(d == {8'h00, ch}, "R4 R5 lockout kept first char", d, {8'h00, ch});
                rd_word(16'hFE00, d, s);
                chk(d == {1'b0, ie[0], 14'h0}, "R5 ready cleared by data read", d, {1'b0, ie[0], 14'h0});
                chk(irq == 1'b0 && kbd_enabled, "R8 R10 after clear", {14'h0, irq, kbd_enabled}, 16'h1);
            end
        end
        wr_word(16'hFE00, 16'h0000);

        // R9 collision
        strobe(8'hA5);
        cycle(1'b1, 1'b0, 16'hFE02, 16'h0, 1'b1, 8'h3C, d, s);
        chk(d == 16'h00A5, "R9 read returns old char", d, 16'h00A5);
        rd_word(16'hFE00, d, s);
        chk(d == 16'h8000, "R9 ready stays set", d, 16'h8000);
        rd_word(16'hFE02, d, s);
        chk(d == 16'h003C, "R9 new char accepted", d, 16'h003C);

        // R7 write to data register ignored
        strobe(8'h5A);
        wr_word(16'hFE02, 16'h00FF);
        rd_word(16'hFE02, d, s);
        chk(d == 16'h005A, "R7 data write ignored", d, 16'h005A);

        // R1 address sweep with a character pending
        strobe(8'h77);
        for (int a = 16'hFE00; a <= 16'hFFFF; a++) begin
            logic [15:0] ad;
            ad = a[15:0];
            if (ad != 16'hFE02) begin
                rd_word(ad, d, s);
                if (ad == 16'hFE00)
                    chk(s && d == 16'h8000, "R1 status hit", d, 16'h8000);
                else
                    chk(!s && d == 16'h0000, "R1 no hit in io window", {15'h0, s}, 16'h0);
            end
        end
        foreach (d[i]) begin
            logic [15:0] ad;
            ad = 16'h1 << i;
            rd_word(ad, d, s);
            chk(!s && d == 16'h0000, "R1 memory address not selected", {15'h0, s}, 16'h0);
        end
        rd_word(16'hFE02, d, s);
        chk(s && d == 16'h0077, "R1 data hit", d, 16'h0077);
        // write cycle never selects
        begin
            logic [15:0] d2; logic s2;
            cycle(1'b0, 1'b1, 16'hFE02, 16'h1234, 1'b0, 8'h0, d2, s2);
            chk(!s2, "R1 no select on write", {15'h0, s2}, 16'h0);
        end

        // R2 reset clears everything mid-run
        wr_word(16'hFE00, 16'h4000);
        strobe(8'h11);
        @(negedge clk); rst = 1; @(posedge clk); #1 rst = 0;
        rd_word(16'hFE00, d, s);
        chk(d == 16'h0000, "R2 reset clears ready and ie", d, 16'h0000);
        rd_word(16'hFE02, d, s);
        chk(d == 16'h0000, "R2 reset clears char", d, 16'h0000);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule